// File: doc/BRIEF.md
# Interleaved Soft-Switching Gate Sequencer

This block drives the gates of a two-phase interleaved boost stage that shares one auxiliary resonant switch. A single tick counter defines the switching period (4000 ticks by default: 25 kHz from a 100 MHz clock). The first phase's main switch turns on at the start of each period. The second phase runs the same waveform shifted by half a period. Each phase takes its own on-time command in ticks.

The shared auxiliary gate pulses ahead of every main-switch edge. Before a turn-on it is high for the programmable turn-on lead, and it drops on the same clock edge on which the main gate rises. Before a turn-off it is high for the longer turn-off lead, and it drops on the same edge on which the main gate falls. That gives four auxiliary pulses per period. Each phase captures its duty command and both leads once per period, at its own period boundary. If the two phases ever ask for the auxiliary switch in the same tick, a sticky flag is raised.

All outputs are registered. Each output reflects the counter state one clock earlier.

Top module: `ileave_gate_seq`

## Requirements
- R1: With enable high, `gateA` is high for the first `onA` ticks of each period of `PERIOD` ticks, where `onA` is the clamped value of `dutyA` (a plain tick count).
- R2: `gateB` follows the same rule with `dutyB`, with its period starting `PERIOD/2` ticks after the period of phase A. The two main gates never rise on the same clock.
- R3: Before every main turn-on, `gateAux` is high for exactly `leadOn` ticks, and it falls on the clock on which that main gate rises.
- R4: Before every main turn-off, `gateAux` is high for exactly `leadOff` ticks, and it falls on the clock on which that main gate falls.
- R5: A lead value of 0 is used as 1. The on-time is clamped to at least `leadOff+1` and at most `PERIOD-leadOn-1`.
- R6: A duty change made in the middle of a period takes effect at the start of that phase's next period. The current pulse keeps the old width.
- R7: While reset is asserted, or on the clock after enable is sampled low, all three gates are low. Re-enabling restarts the counter at phase A's period start.
- R8: After enable rises, a main gate stays low until its first turn-on auxiliary pulse has completed. No turn-off auxiliary pulse is issued for a phase that has not yet been armed.
- R9: `overlapErr` becomes high on the clock on which both phases drive the auxiliary request in the same tick. It stays high until reset; disabling does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequencer; low forces all gates low |
| dutyA | input | DUTY_W | Phase A on-time command in ticks |
| dutyB | input | DUTY_W | Phase B on-time command in ticks |
| leadOff | input | LEAD_W | Auxiliary lead before a main turn-off, in ticks |
| leadOn | input | LEAD_W | Auxiliary lead before a main turn-on, in ticks |
| gateA | output | 1 | Phase A main switch gate |
| gateB | output | 1 | Phase B main switch gate |
| gateAux | output | 1 | Shared auxiliary switch gate |
| overlapErr | output | 1 | Sticky flag for auxiliary requests that collide between phases |

## Verification
A counter or phase offset that slips shows up within one period as a main edge at the wrong tick, or as a main edge with no auxiliary pulse directly before it. A bad captured configuration changes a pulse width in the same period it is used. Wrong arming shows up in the first period after enable, as a main gate or turn-off pulse that should be absent. The sticky flag is compared every clock against the overlap predicted from both phases' windows, so a missed or spurious collision is seen on the very next clock.

// File: rtl/ileave_gate_pkg.sv
package ileave_gate_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic       run;
    logic [1:0] loadCfg;
    logic [1:0] armed;
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic [1:0] wrapNext;
    logic [1:0] auxReq;
  } seqStat_t;

endpackage

// File: rtl/ileave_gate_dp.sv
module ileave_gate_dp
  import ileave_gate_pkg::*;
#(
  parameter int PERIOD = 4000,
  parameter int DUTY_W = 12,
  parameter int LEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyA,
  input  logic [DUTY_W-1:0] dutyB,
  input  logic [LEAD_W-1:0] leadOff,
  input  logic [LEAD_W-1:0] leadOn,
  input  seqCtrl_t          ctrl,
  output seqStat_t          stat,
  output logic              gateA,
  output logic              gateB,
  output logic              gateAux
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam int HALF  = PERIOD / 2;
  localparam int NPH   = 2;

  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] dutyArr [NPH];
  logic [NPH-1:0]    mainReqV;
  logic [NPH-1:0]    auxReqV;
  logic [NPH-1:0]    wrapV;

  assign dutyArr[0] = dutyA;
  assign dutyArr[1] = dutyB;

  // shared timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (!ctrl.run)                 cnt <= '0;
    else if (cnt == CNT_W'(PERIOD - 1)) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    localparam int OFFS = i * HALF;

    logic [31:0]       phSum, phW;
    logic [31:0]       lofW, lonW, loW, hiW, dutyW, onW;
    logic [CNT_W-1:0]  onQ;
    logic [LEAD_W-1:0] lofQ, lonQ;
    logic              auxOn, auxOff;

    // phase-local position in the period
    always_comb begin
      phSum = 32'(cnt) + 32'(OFFS);
      phW   = (phSum >= 32'(PERIOD)) ? phSum - 32'(PERIOD) : phSum;
    end

    // lead floor and on-time clamp
    always_comb begin
      lofW  = (leadOff == '0) ? 32'd1 : 32'(leadOff);
      lonW  = (leadOn  == '0) ? 32'd1 : 32'(leadOn);
      loW   = lofW + 32'd1;
      hiW   = 32'(PERIOD) - lonW - 32'd1;
      dutyW = 32'(dutyArr[i]);
      if (dutyW < loW)      onW = loW;
      else if (dutyW > hiW) onW = hiW;
      else                  onW = dutyW;
    end

    // configuration captured at this phase's boundary
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onQ  <= '0;
        lofQ <= '0;
        lonQ <= '0;
      end else if (ctrl.loadCfg[i]) begin
        onQ  <= CNT_W'(onW);
        lofQ <= LEAD_W'(lofW);
        lonQ <= LEAD_W'(lonW);
      end
    end

    always_comb begin
      auxOn  = phW >= (32'(PERIOD) - 32'(lonQ));
      auxOff = ctrl.armed[i] && (phW + 32'(lofQ) >= 32'(onQ)) && (phW < 32'(onQ));
    end

    assign mainReqV[i] = ctrl.armed[i] && (phW < 32'(onQ));
    assign auxReqV[i]  = auxOn | auxOff;
    assign wrapV[i]    = (phW == 32'(PERIOD - 1));
  end

  assign stat = '{wrapNext: wrapV, auxReq: auxReqV};

  // registered gate outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateA   <= 1'b0;
      gateB   <= 1'b0;
      gateAux <= 1'b0;
    end else begin
      gateA   <= ctrl.run & mainReqV[0];
      gateB   <= ctrl.run & mainReqV[1];
      gateAux <= ctrl.run & (|auxReqV);
    end
  end

endmodule

// File: rtl/ileave_gate_ctl.sv
module ileave_gate_ctl
  import ileave_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     overlapErr
);

  logic [1:0] armed;

  // a phase is armed once its first turn-on lead has run out
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= '0;
    else if (!enable) armed <= '0;
    else              armed <= armed | stat.wrapNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          overlapErr <= 1'b0;
    else if (enable && (&stat.auxReq))  overlapErr <= 1'b1;
  end

  always_comb begin
    ctrl.run     = enable;
    ctrl.loadCfg = enable ? stat.wrapNext : 2'b11;
    ctrl.armed   = armed;
  end

endmodule

// File: rtl/ileave_gate_seq.sv
module ileave_gate_seq
  import ileave_gate_pkg::*;
#(
  parameter int PERIOD = 4000,
  parameter int DUTY_W = 12,
  parameter int LEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DUTY_W-1:0] dutyA,
  input  logic [DUTY_W-1:0] dutyB,
  input  logic [LEAD_W-1:0] leadOff,
  input  logic [LEAD_W-1:0] leadOn,
  output logic              gateA,
  output logic              gateB,
  output logic              gateAux,
  output logic              overlapErr
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  ileave_gate_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .stat       (stat),
    .ctrl       (ctrl),
    .overlapErr (overlapErr)
  );

  ileave_gate_dp #(
    .PERIOD (PERIOD),
    .DUTY_W (DUTY_W),
    .LEAD_W (LEAD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dutyA   (dutyA),
    .dutyB   (dutyB),
    .leadOff (leadOff),
    .leadOn  (leadOn),
    .ctrl    (ctrl),
    .stat    (stat),
    .gateA   (gateA),
    .gateB   (gateB),
    .gateAux (gateAux)
  );

endmodule

// File: rtl/ileave_gate_chk.sv
module ileave_gate_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic gateA,
  input logic gateB,
  input logic gateAux,
  input logic overlapErr
);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!gateA && !gateB && !gateAux));

  assert_lead_on_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateA) |-> $past(gateAux));

  assert_lead_on_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateB) |-> $past(gateAux));

  assert_lead_off_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateA) && $past(enable)) |-> $past(gateAux));

  assert_lead_off_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateB) && $past(enable)) |-> $past(gateAux));

  assert_no_joint_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(gateA) && $rose(gateB)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(overlapErr) |-> overlapErr);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overlapErr) |-> gateAux);

endmodule

bind ileave_gate_seq ileave_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .gateA      (gateA),
  .gateB      (gateB),
  .gateAux    (gateAux),
  .overlapErr (overlapErr)
);

// File: tb/sim_ileave_gate_seq.sv
`timescale 1ns/1ps
module sim_ileave_gate_seq;

  localparam int P  = 64;
  localparam int H  = P / 2;
  localparam int DW = 7;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [DW-1:0] dutyA = '0;
  logic [DW-1:0] dutyB = '0;
  logic [LW-1:0] leadOff = '0;
  logic [LW-1:0] leadOn = '0;
  logic          gateA, gateB, gateAux, overlapErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int onE [2];
  int lofE[2];
  int lonE[2];
  int stg [2];
  bit armE[2];
  bit errE;

  always #2.5 clk = ~clk;

  ileave_gate_seq #(.PERIOD(P), .DUTY_W(DW), .LEAD_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .dutyA(dutyA), .dutyB(dutyB),
    .leadOff(leadOff), .leadOn(leadOn), .gateA(gateA), .gateB(gateB),
    .gateAux(gateAux), .overlapErr(overlapErr)
  );

  task automatic chk(string tag, string what, logic act, logic exp, int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s tick %0d actual %0b expected %0b", tag, what, t, act, exp);
    end
  endtask

  function automatic int fixLead(int l);
    return (l == 0) ? 1 : l;
  endfunction

  // R5 on-time clamp
  function automatic int clampOn(int d, int lof, int lon);
    int lo, hi;
    lo = fixLead(lof) + 1;
    hi = P - fixLead(lon) - 1;
    if (d < lo) return lo;
    if (d > hi) return hi;
    return d;
  endfunction

  function automatic int phOf(int i, int t);
    return (i == 0) ? (t % P) : ((t + H) % P);
  endfunction

  task automatic runSeq(bit doReset, int dA, int dB, int lof, int lon,
                        int nTicks, int chgAt, int nA, int nB, string baseTag);
    enable  = 1'b0;
    dutyA   = DW'(dA);
    dutyB   = DW'(dB);
    leadOff = LW'(lof);
    leadOn  = LW'(lon);
    if (doReset) begin
      rstN = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R7", "gateA in reset", gateA, 1'b0, -1);
      chk("R7", "gateB in reset", gateB, 1'b0, -1);
      chk("R7", "gateAux in reset", gateAux, 1'b0, -1);
      chk("R9", "overlapErr in reset", overlapErr, 1'b0, -1);
      rstN = 1'b1;
      errE = 1'b0;
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      onE[i]  = clampOn((i == 0) ? dA : dB, lof, lon);
      lofE[i] = fixLead(lof);
      lonE[i] = fixLead(lon);
      stg[i]  = onE[i];
      armE[i] = 1'b0;
    end
    enable = 1'b1;
    for (int t = 0; t < nTicks; t++) begin
      bit mE[2];
      bit aE[2];
      string tg;
      @(posedge clk);
      #1;
      for (int i = 0; i < 2; i++) begin
        int ph;
        if (t >= 1 && phOf(i, t - 1) == P - 1) begin
          onE[i]  = stg[i];
          armE[i] = 1'b1;
        end
        ph = phOf(i, t);
        mE[i] = armE[i] && (ph < onE[i]);
        aE[i] = (ph >= P - lonE[i]) ||
                (armE[i] && (ph >= onE[i] - lofE[i]) && (ph < onE[i]));
      end
      if (aE[0] && aE[1]) errE = 1'b1;
      tg = (t < P) ? "R8" : baseTag;
      chk(tg, "gateA R1", gateA, mE[0], t);
      chk(tg, "gateB R2", gateB, mE[1], t);
      chk(tg, "gateAux R3 R4", gateAux, aE[0] | aE[1], t);
      chk("R9", "overlapErr", overlapErr, errE, t);
      if (t == chgAt) begin
        dutyA = DW'(nA);
        dutyB = DW'(nB);
      end
      for (int i = 0; i < 2; i++)
        if (phOf(i, t + 1) == P - 1)
          stg[i] = clampOn((i == 0) ? int'(dutyA) : int'(dutyB), lof, lon);
    end
    // R7: disable drops every gate on the next clock, flag is kept (R9)
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      chk("R7", "gateA disabled", gateA, 1'b0, k);
      chk("R7", "gateB disabled", gateB, 1'b0, k);
      chk("R7", "gateAux disabled", gateAux, 1'b0, k);
      chk("R9", "overlapErr kept", overlapErr, errE, k);
    end
  endtask

  initial begin
    int duties[13] = '{0, 1, 3, 9, 16, 20, 31, 32, 33, 47, 55, 90, 127};
    int lofs[5]    = '{4, 8, 3, 15, 0};
    int lons[5]    = '{2, 1, 0, 7, 5};
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 13; j++) begin
        int dA, dB;
        string tg;
        dA = duties[j];
        dB = duties[(j + 5) % 13];
        tg = (clampOn(dA, lofs[k], lons[k]) != dA ||
              clampOn(dB, lofs[k], lons[k]) != dB) ? "R5" : "R1";
        runSeq((j % 3) == 0, dA, dB, lofs[k], lons[k], 3 * P + H, -1, 0, 0, tg);
      end
    end
    // R6: mid-period duty change applies from the next period of each phase
    runSeq(1'b1, 20, 10, 4, 2, 4 * P, P + 36, 40, 25, "R6");
    runSeq(1'b0, 40, 25, 4, 2, 3 * P, 2 * P + 5, 12, 50, "R6");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule